// File: doc/BRIEF.md
# SPI Flash Serial Command Front End

This block is the device side of a serial NOR flash model. It watches the serial clock, the active-low select and the data-in line from a fast system clock, assembles each opcode, address and dummy byte, and shifts read data back on one line or, for the dual-output fast read, on two lines at once. Read data comes from an external byte memory through a simple request port. The status byte is supplied by a neighbouring block. The identification bytes are fixed by parameters.

The block also tracks deep power-down. When the select line rises, it reports every accepted transaction on a one-cycle command-complete strobe. The strobe carries the opcode and a flag that says whether the transaction ended on a whole byte. A neighbouring write/erase engine uses that flag to decide whether to act. Bus modes 0 and 3 both work, because only clock edges are used and never the idle level.

Top module: `spi_flash_frontend`

## Requirements
- R1: After reset both IO output enables, the power-down flag, the memory request and the command strobe are all 0.
- R2: After reset the device stays unselected until a falling edge of the select line is seen. With select already low at reset, a whole transaction draws no output, no memory request and no command strobe.
- R3: Opcode 03h takes a 3-byte address, MSB first. Data starts on the next falling clock edge. Each output byte comes from the memory port at an address one higher than the previous byte, and the stream carries on across byte-address carries until select rises.
- R4: Opcode 0Bh takes a 3-byte address and then one dummy byte before the data, which is streamed as in R3. This works in bus mode 3 as well as in mode 0.
- R5: Opcode 3Bh behaves like 0Bh but sends two bits per clock. IO1 carries bits 7, 5, 3, 1 and IO0 carries bits 6, 4, 2, 0. IO0 is enabled as an output only after the dummy byte.
- R6: Opcode 05h returns the status input byte repeatedly. It is served while WIP is 1.
- R7: Opcode 9Fh returns 68h, 40h, 13h and then repeats that sequence.
- R8: Opcode 90h takes a 3-byte address. Bit 0 of that address equal to 0 gives 68h then 12h, and equal to 1 gives 12h then 68h. The two bytes then alternate.
- R9: Opcode ABh takes three dummy bytes and then returns 12h on every following byte.
- R10: Opcode B9h sets the power-down flag only when select rises after exactly 8 clocks. Any other length leaves the flag clear.
- R11: While powered down, every opcode except ABh is ignored: no output, no memory request and no strobe. That includes 05h. An ABh transaction clears the flag when select rises.
- R12: With WIP at 1, opcodes 03h, 0Bh, 3Bh, 9Fh, 90h and ABh are rejected: no output, no memory request and no strobe.
- R13: When select rises after at least one full opcode of an accepted transaction, a one-cycle strobe gives the opcode. The aligned flag is 1 exactly when the clock count is a multiple of 8.
- R14: Both IO output enables are 0 outside the data-out phase, including the opcode, address and dummy bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the bus master |
| cs_n | input | 1 | Active-low select |
| io0_in | input | 1 | Serial data in (IO0 line as input) |
| io0_out | output | 1 | IO0 output value (dual mode only) |
| io0_oe | output | 1 | IO0 output enable |
| io1_out | output | 1 | IO1 / serial data out value |
| io1_oe | output | 1 | IO1 output enable |
| wip | input | 1 | Write-in-progress from the program/erase engine |
| status_in | input | 8 | Status byte to return for 05h |
| mem_req | output | 1 | One-cycle read request for mem_addr |
| mem_addr | output | 24 | Byte address of the request |
| mem_rdata | input | 8 | Read data, valid one clock after mem_req and held |
| cmd_done | output | 1 | One-cycle command-complete strobe |
| cmd_opcode | output | 8 | Opcode of the completed transaction |
| cmd_aligned | output | 1 | Transaction ended on a byte boundary |
| dpd_active | output | 1 | Deep power-down flag |

## Verification
A serial edge acts inside the block three system clocks after it reaches the pins: two synchroniser flops plus the edge register. An output bit therefore changes about four system clocks after a falling serial edge, and the command strobe fires about three clocks after select rises. The bench holds each serial half period for six system clocks and samples IO just before it raises the serial clock. It reads the strobe log twelve clocks after releasing select, so every result has settled before it is compared with the reference model.

// File: rtl/spiffe_pkg.sv
package spiffe_pkg;

    typedef enum logic [2:0] {
        PH_OPC,
        PH_ADDR,
        PH_DUMMY,
        PH_DATA,
        PH_HOLD,
        PH_SKIP
    } phase_e;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_MEM,
        SRC_STAT,
        SRC_JID,
        SRC_MID,
        SRC_DID
    } src_e;

    typedef struct packed {
        logic addr3;
        logic dummy;
        logic dual;
        logic wip_block;
        src_e src;
    } cmd_info_t;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_FAST  = 8'h0B;
    localparam logic [7:0] OP_DUAL  = 8'h3B;
    localparam logic [7:0] OP_STAT  = 8'h05;
    localparam logic [7:0] OP_JID   = 8'h9F;
    localparam logic [7:0] OP_MID   = 8'h90;
    localparam logic [7:0] OP_RDP   = 8'hAB;
    localparam logic [7:0] OP_DPD   = 8'hB9;

    function automatic cmd_info_t decode_op(input logic [7:0] op);
        cmd_info_t c;
        c.addr3     = 1'b0;
        c.dummy     = 1'b0;
        c.dual      = 1'b0;
        c.wip_block = 1'b0;
        c.src       = SRC_NONE;
        case (op)
            OP_READ: begin c.addr3 = 1'b1; c.wip_block = 1'b1; c.src = SRC_MEM; end
            OP_FAST: begin c.addr3 = 1'b1; c.dummy = 1'b1; c.wip_block = 1'b1; c.src = SRC_MEM; end
            OP_DUAL: begin c.addr3 = 1'b1; c.dummy = 1'b1; c.dual = 1'b1; c.wip_block = 1'b1; c.src = SRC_MEM; end
            OP_STAT: begin c.src = SRC_STAT; end
            OP_JID:  begin c.wip_block = 1'b1; c.src = SRC_JID; end
            OP_MID:  begin c.addr3 = 1'b1; c.wip_block = 1'b1; c.src = SRC_MID; end
            OP_RDP:  begin c.addr3 = 1'b1; c.wip_block = 1'b1; c.src = SRC_DID; end
            default: ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/spiffe_sync.sv
module spiffe_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/spiffe_ctrl.sv
module spiffe_ctrl
    import spiffe_pkg::*;
#(
    parameter int         ADDR_W  = 24,
    parameter logic [7:0] MFR_ID  = 8'h68,
    parameter logic [7:0] TYPE_ID = 8'h40,
    parameter logic [7:0] CAP_ID  = 8'h13,
    parameter logic [7:0] DEV_ID  = 8'h12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              mosi_s,
    input  logic              wip,
    input  logic [7:0]        status_in,
    input  logic [7:0]        mem_rdata,
    input  logic              tx_taken,
    output logic              data_en,
    output logic              sclk_fall,
    output logic              tx_dual,
    output logic [7:0]        tx_byte,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              cmd_done,
    output logic [7:0]        cmd_opcode,
    output logic              cmd_aligned,
    output logic              dpd
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int LEFT_W     = $clog2(ADDR_BYTES + 1);

    logic              sclk_q, cs_q, sel;
    logic [2:0]        bit_cnt;
    logic [1:0]        byte_cnt;
    logic [6:0]        shreg;
    logic [7:0]        opcode;
    phase_e            phase;
    src_e              cur_src;
    logic              cur_dummy;
    logic [LEFT_W-1:0] left;
    logic [ADDR_W-1:0] addr;
    logic [1:0]        idx;

    wire sclk_rise = sclk_s & ~sclk_q;
    wire cs_fall   = ~cs_s & cs_q;
    wire cs_rise   = cs_s & ~cs_q;
    wire [7:0] rx_byte = {shreg, mosi_s};
    cmd_info_t dec;

    always_comb dec = decode_op(rx_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0; cs_q <= 1'b0; sel <= 1'b0;
            bit_cnt <= '0; byte_cnt <= '0; shreg <= '0; opcode <= '0;
            phase <= PH_OPC; cur_src <= SRC_NONE; cur_dummy <= 1'b0; tx_dual <= 1'b0;
            left <= '0; addr <= '0; idx <= '0;
            mem_req <= 1'b0; cmd_done <= 1'b0; cmd_opcode <= '0; cmd_aligned <= 1'b0;
            dpd <= 1'b0;
        end else begin
            sclk_q   <= sclk_s;
            cs_q     <= cs_s;
            mem_req  <= 1'b0;
            cmd_done <= 1'b0;
            if (cs_fall) begin
                sel      <= 1'b1;
                bit_cnt  <= '0;
                byte_cnt <= '0;
                phase    <= PH_OPC;
            end else if (cs_rise) begin
                sel <= 1'b0;
                if (sel && byte_cnt != 2'd0 && phase != PH_SKIP) begin
                    cmd_done    <= 1'b1;
                    cmd_opcode  <= opcode;
                    cmd_aligned <= (bit_cnt == 3'd0);
                    if (opcode == OP_DPD && byte_cnt == 2'd1 && bit_cnt == 3'd0) dpd <= 1'b1;
                    if (opcode == OP_RDP) dpd <= 1'b0;
                end
            end else if (sel && sclk_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                shreg   <= rx_byte[6:0];
                if (bit_cnt == 3'd7) begin
                    if (byte_cnt != 2'd3) byte_cnt <= byte_cnt + 2'd1;
                    case (phase)
                        PH_OPC: begin
                            opcode    <= rx_byte;
                            cur_src   <= dec.src;
                            cur_dummy <= dec.dummy;
                            tx_dual   <= dec.dual;
                            idx       <= 2'd0;
                            if ((dpd && rx_byte != OP_RDP) || (wip && dec.wip_block))
                                phase <= PH_SKIP;
                            else if (dec.addr3) begin
                                phase <= PH_ADDR;
                                left  <= LEFT_W'(ADDR_BYTES - 1);
                            end else if (dec.src != SRC_NONE)
                                phase <= PH_DATA;
                            else
                                phase <= PH_HOLD;
                        end
                        PH_ADDR: begin
                            addr <= {addr[ADDR_W-9:0], rx_byte};
                            if (left == '0) begin
                                if (cur_dummy) phase <= PH_DUMMY;
                                else begin
                                    phase   <= PH_DATA;
                                    mem_req <= (cur_src == SRC_MEM);
                                    idx     <= {1'b0, rx_byte[0]};
                                end
                            end else begin
                                left <= left - LEFT_W'(1);
                            end
                        end
                        PH_DUMMY: begin
                            phase   <= PH_DATA;
                            mem_req <= (cur_src == SRC_MEM);
                            idx     <= {1'b0, addr[0]};
                        end
                        default: ;
                    endcase
                end
            end else if (tx_taken && data_en) begin
                addr    <= addr + ADDR_W'(1);
                mem_req <= (cur_src == SRC_MEM);
                idx     <= (cur_src == SRC_JID && idx == 2'd2) ? 2'd0 : idx + 2'd1;
            end
        end
    end

    always_comb begin
        case (cur_src)
            SRC_MEM:  tx_byte = mem_rdata;
            SRC_STAT: tx_byte = status_in;
            SRC_JID:  tx_byte = (idx == 2'd0) ? MFR_ID : (idx == 2'd1) ? TYPE_ID : CAP_ID;
            SRC_MID:  tx_byte = idx[0] ? DEV_ID : MFR_ID;
            SRC_DID:  tx_byte = DEV_ID;
            default:  tx_byte = 8'h00;
        endcase
    end

    assign data_en   = sel && (phase == PH_DATA);
    assign sclk_fall = sclk_q & ~sclk_s;
    assign mem_addr  = addr;

    p_mem_req_src_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (cur_src == SRC_MEM));
    p_dpd_entry_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(dpd) |-> (opcode == OP_DPD));
    p_dpd_filter_r11: assert property (@(posedge clk) disable iff (rst)
        (sel && dpd && phase inside {PH_ADDR, PH_DUMMY, PH_DATA, PH_HOLD}) |-> (opcode == OP_RDP));
    p_skip_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SKIP) |=> !mem_req && !cmd_done);
    p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        cmd_done |=> !cmd_done);
endmodule

// File: rtl/spiffe_tx.sv
module spiffe_tx (
    input  logic       clk,
    input  logic       rst,
    input  logic       data_en,
    input  logic       sclk_fall,
    input  logic       dual,
    input  logic [7:0] tx_byte,
    output logic       taken,
    output logic       io0_out,
    output logic       io0_oe,
    output logic       io1_out,
    output logic       io1_oe
);
    logic [7:0] sh;
    logic [2:0] remain;

    always_ff @(posedge clk) begin
        if (rst || !data_en) begin
            sh <= '0; remain <= '0; taken <= 1'b0;
            io0_out <= 1'b0; io1_out <= 1'b0; io0_oe <= 1'b0; io1_oe <= 1'b0;
        end else begin
            taken <= 1'b0;
            if (sclk_fall) begin
                if (remain == 3'd0) begin
                    taken   <= 1'b1;
                    io1_out <= tx_byte[7];
                    io1_oe  <= 1'b1;
                    if (dual) begin
                        io0_out <= tx_byte[6];
                        io0_oe  <= 1'b1;
                        sh      <= {tx_byte[5:0], 2'b00};
                        remain  <= 3'd3;
                    end else begin
                        sh     <= {tx_byte[6:0], 1'b0};
                        remain <= 3'd7;
                    end
                end else begin
                    io1_out <= sh[7];
                    if (dual) begin
                        io0_out <= sh[6];
                        sh      <= {sh[5:0], 2'b00};
                    end else begin
                        sh <= {sh[6:0], 1'b0};
                    end
                    remain <= remain - 3'd1;
                end
            end
        end
    end

    p_dual_pair_r5: assert property (@(posedge clk) disable iff (rst)
        io0_oe |-> io1_oe);
    p_oe_release_r14: assert property (@(posedge clk) disable iff (rst)
        !data_en |=> (!io0_oe && !io1_oe));
endmodule

// File: rtl/spi_flash_frontend.sv
module spi_flash_frontend #(
    parameter int         ADDR_W      = 24,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] MFR_ID      = 8'h68,
    parameter logic [7:0] TYPE_ID     = 8'h40,
    parameter logic [7:0] CAP_ID      = 8'h13,
    parameter logic [7:0] DEV_ID      = 8'h12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              io0_in,
    output logic              io0_out,
    output logic              io0_oe,
    output logic              io1_out,
    output logic              io1_oe,
    input  logic              wip,
    input  logic [7:0]        status_in,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic              cmd_done,
    output logic [7:0]        cmd_opcode,
    output logic              cmd_aligned,
    output logic              dpd_active
);
    logic [2:0] pins_s;
    logic       data_en, sclk_fall, tx_dual, tx_taken;
    logic [7:0] tx_byte;

    spiffe_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d({cs_n, sclk, io0_in}), .q(pins_s)
    );

    spiffe_ctrl #(
        .ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .TYPE_ID(TYPE_ID),
        .CAP_ID(CAP_ID), .DEV_ID(DEV_ID)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .cs_s(pins_s[2]), .sclk_s(pins_s[1]), .mosi_s(pins_s[0]),
        .wip(wip), .status_in(status_in), .mem_rdata(mem_rdata),
        .tx_taken(tx_taken), .data_en(data_en), .sclk_fall(sclk_fall),
        .tx_dual(tx_dual), .tx_byte(tx_byte),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .cmd_done(cmd_done), .cmd_opcode(cmd_opcode), .cmd_aligned(cmd_aligned),
        .dpd(dpd_active)
    );

    spiffe_tx u_tx (
        .clk(clk), .rst(rst), .data_en(data_en), .sclk_fall(sclk_fall),
        .dual(tx_dual), .tx_byte(tx_byte), .taken(tx_taken),
        .io0_out(io0_out), .io0_oe(io0_oe), .io1_out(io1_out), .io1_oe(io1_oe)
    );
endmodule

// File: tb/test_spi_flash_frontend.sv
module test_spi_flash_frontend;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst, sclk, cs_n, mosi, wip;
    logic [7:0]  status_in;
    logic        io0_out, io0_oe, io1_out, io1_oe;
    logic        mem_req;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic        cmd_done, cmd_aligned, dpd_active;
    logic [7:0]  cmd_opcode;

    always #5 clk = ~clk;

    spi_flash_frontend i_spi_flash_frontend (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .io0_in(mosi),
        .io0_out(io0_out), .io0_oe(io0_oe), .io1_out(io1_out), .io1_oe(io1_oe),
        .wip(wip), .status_in(status_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .cmd_done(cmd_done), .cmd_opcode(cmd_opcode), .cmd_aligned(cmd_aligned),
        .dpd_active(dpd_active)
    );

    int checks = 0, fails = 0, reqs = 0, dones = 0;
    logic [7:0] last_op;
    logic       last_al;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];
    bit pre_oe, rx_noe;

    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
    endfunction

    always @(posedge clk) begin
        if (rst) mem_rdata <= 8'h00;
        else if (mem_req) begin mem_rdata <= memf(mem_addr); reqs++; end
        if (!rst && cmd_done) begin dones++; last_op <= cmd_opcode; last_al <= cmd_aligned; end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sclk = 1'b0; mosi = b; tick(HALF);
        if (io0_oe || io1_oe) pre_oe = 1'b1;
        sclk = 1'b1; tick(HALF);
    endtask

    task automatic spi_txn(input bit mode3, input int extra, input int nrx, input bit dual);
        logic [7:0] v;
        pre_oe = 1'b0; rx_noe = 1'b0; rxq.delete();
        sclk = mode3; tick(HALF);
        cs_n = 1'b0; tick(HALF);
        foreach (txq[i]) for (int b = 7; b >= 0; b--) send_bit(txq[i][b]);
        for (int e = 0; e < extra; e++) send_bit(1'b1);
        for (int r = 0; r < nrx; r++) begin
            v = 8'h00;
            for (int k = 0; k < (dual ? 4 : 8); k++) begin
                sclk = 1'b0; mosi = 1'b0; tick(HALF);
                if (!io1_oe || (dual && !io0_oe)) rx_noe = 1'b1;
                if (dual) v = {v[5:0], io1_out, io0_out};
                else      v = {v[6:0], io1_out};
                sclk = 1'b1; tick(HALF);
            end
            rxq.push_back(v);
        end
        if (!mode3) begin sclk = 1'b0; tick(HALF); end
        cs_n = 1'b1; tick(2 * HALF);
    endtask

    task automatic chk_rx(input string req, input int i, input logic [7:0] exp);
        check(i < rxq.size() && rxq[i] == exp, req, $sformatf("rx byte %0d", i),
              (i < rxq.size()) ? int'(rxq[i]) : -1, int'(exp));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int r0, d0;
        rst = 1'b1; cs_n = 1'b0; sclk = 1'b0; mosi = 1'b0; wip = 1'b0; status_in = 8'h9C;
        tick(5); rst = 1'b0; tick(2);

        // R1: reset state
        check(!io0_oe && !io1_oe, "R1", "oe after reset", {io0_oe, io1_oe}, 0);
        check(!dpd_active && !mem_req && !cmd_done, "R1", "flags after reset",
              {dpd_active, mem_req, cmd_done}, 0);

        // R2: select low at reset, no falling edge yet
        txq = {8'h9F};
        spi_txn(1'b0, 0, 3, 1'b0);
        check(rx_noe, "R2", "output enabled without arming", 0, 1);
        check(dones == 0 && reqs == 0, "R2", "strobe/request without arming", dones + reqs, 0);

        // R3 + R13: read with carry across byte address
        r0 = reqs; d0 = dones;
        txq = {8'h03, 8'h01, 8'h23, 8'hFE};
        spi_txn(1'b0, 0, 4, 1'b0);
        chk_rx("R3", 0, memf(24'h0123FE));
        chk_rx("R3", 1, memf(24'h0123FF));
        chk_rx("R3", 2, memf(24'h012400));
        chk_rx("R3", 3, memf(24'h012401));
        check(!rx_noe, "R3", "oe during data", rx_noe, 0);
        check(reqs - r0 >= 4, "R3", "memory requests", reqs - r0, 4);
        check(dones == d0 + 1 && last_op == 8'h03 && last_al, "R13", "read strobe",
              {last_op, 7'b0, last_al}, {8'h03, 8'h01});
        check(!pre_oe, "R14", "oe before data (03h)", pre_oe, 0);

        // R4: fast read in mode 3
        txq = {8'h0B, 8'h7F, 8'hFF, 8'hF0, 8'h00};
        spi_txn(1'b1, 0, 3, 1'b0);
        chk_rx("R4", 0, memf(24'h7FFFF0));
        chk_rx("R4", 1, memf(24'h7FFFF1));
        chk_rx("R4", 2, memf(24'h7FFFF2));
        check(!pre_oe, "R14", "oe before data (0Bh)", pre_oe, 0);

        // R5: dual output
        txq = {8'h3B, 8'h00, 8'h00, 8'h10, 8'h00};
        spi_txn(1'b0, 0, 3, 1'b1);
        chk_rx("R5", 0, memf(24'h000010));
        chk_rx("R5", 1, memf(24'h000011));
        chk_rx("R5", 2, memf(24'h000012));
        check(!pre_oe, "R5", "IO0 enabled before dummy end", pre_oe, 0);
        check(!rx_noe, "R5", "both lines driven in data", rx_noe, 0);

        // R6: status read while busy
        wip = 1'b1;
        txq = {8'h05};
        spi_txn(1'b0, 0, 3, 1'b0);
        chk_rx("R6", 0, 8'h9C); chk_rx("R6", 2, 8'h9C);
        wip = 1'b0;

        // R7: JEDEC-style identification
        txq = {8'h9F};
        spi_txn(1'b1, 0, 4, 1'b0);
        chk_rx("R7", 0, 8'h68); chk_rx("R7", 1, 8'h40);
        chk_rx("R7", 2, 8'h13); chk_rx("R7", 3, 8'h68);

        // R8: manufacturer/device order
        txq = {8'h90, 8'h00, 8'h00, 8'h00};
        spi_txn(1'b0, 0, 3, 1'b0);
        chk_rx("R8", 0, 8'h68); chk_rx("R8", 1, 8'h12); chk_rx("R8", 2, 8'h68);
        txq = {8'h90, 8'h00, 8'h00, 8'h01};
        spi_txn(1'b0, 0, 2, 1'b0);
        chk_rx("R8", 0, 8'h12); chk_rx("R8", 1, 8'h68);

        // R9: device ID after three dummies
        txq = {8'hAB, 8'h00, 8'h00, 8'h00};
        spi_txn(1'b0, 0, 2, 1'b0);
        chk_rx("R9", 0, 8'h12); chk_rx("R9", 1, 8'h12);

        // R12: reads rejected while busy
        wip = 1'b1; r0 = reqs; d0 = dones;
        txq = {8'h03, 8'h00, 8'h00, 8'h00};
        spi_txn(1'b0, 0, 2, 1'b0);
        check(rx_noe && reqs == r0, "R12", "read while busy", reqs - r0, 0);
        txq = {8'h9F};
        spi_txn(1'b0, 0, 1, 1'b0);
        check(rx_noe && dones == d0, "R12", "id while busy", dones - d0, 0);
        wip = 1'b0;

        // R13: strobe for non-read opcodes, aligned and not
        d0 = dones;
        txq = {8'h06};
        spi_txn(1'b0, 0, 0, 1'b0);
        check(dones == d0 + 1 && last_op == 8'h06 && last_al, "R13", "aligned strobe",
              {last_op, 7'b0, last_al}, {8'h06, 8'h01});
        txq = {8'h02};
        spi_txn(1'b0, 4, 0, 1'b0);
        check(dones == d0 + 2 && last_op == 8'h02 && !last_al, "R13", "unaligned strobe",
              {last_op, 7'b0, last_al}, {8'h02, 8'h00});

        // R10: power-down needs exactly 8 clocks
        txq = {8'hB9};
        spi_txn(1'b0, 1, 0, 1'b0);
        check(!dpd_active, "R10", "9-bit power-down", dpd_active, 0);
        txq = {8'hB9};
        spi_txn(1'b0, 0, 0, 1'b0);
        check(dpd_active, "R10", "8-bit power-down", dpd_active, 1);

        // R11: only ABh honoured while powered down
        r0 = reqs; d0 = dones;
        txq = {8'h05};
        spi_txn(1'b0, 0, 1, 1'b0);
        check(rx_noe && dones == d0, "R11", "status in power-down", dones - d0, 0);
        txq = {8'h03, 8'h00, 8'h00, 8'h00};
        spi_txn(1'b0, 0, 1, 1'b0);
        check(rx_noe && reqs == r0 && dpd_active, "R11", "read in power-down", reqs - r0, 0);
        txq = {8'hAB, 8'h00, 8'h00, 8'h00};
        spi_txn(1'b0, 0, 1, 1'b0);
        chk_rx("R11", 0, 8'h12);
        check(!dpd_active, "R11", "release", dpd_active, 0);
        txq = {8'h9F};
        spi_txn(1'b0, 0, 1, 1'b0);
        chk_rx("R11", 0, 8'h68);

        // R14: idle lines released
        tick(4);
        check(!io0_oe && !io1_oe, "R14", "oe while deselected", {io0_oe, io1_oe}, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule